// File: doc/BRIEF.md
# Fast PWM Timer with Buffered Compare Channels

This block is a 16-bit up-counting timer for pulse-width modulation. Each timer tick comes from a prescaler that divides the input clock by 1, 8, 64, 256 or 1024. On every tick the counter advances from zero towards a period limit (TOP) and clears to zero on the tick after it reaches that limit. The limit can be one of three fixed widths (8, 9 or 10 bits). It can also come from an unbuffered period register, or from the active compare value of channel A.

Two compare channels, A and B, each hold a write buffer and an active compare value. A new compare value written through the register port goes into the buffer. It reaches the active value only on the tick at which the counter sits at TOP, so a duty change never cuts a period short. Each channel drives a waveform pin in one of four output modes: off, toggle on match (channel A only), non-inverted PWM, or inverted PWM. The period register has no buffer. A value written below the current count sends the counter through 0xFFFF before it can match.

Top module: `fpwm_timer`

## Requirements
- R1: While `enable` is high the counter advances once every N clocks, where `presc_sel` values 0, 1, 2, 3 and 4 select N = 1, 8, 64, 256 and 1024. With `enable` low or `presc_sel` at 5 to 7 the counter holds its value.
- R2: The counter steps from 0 up to TOP and clears to 0 on the following tick. `ovf_flag` is high for exactly the one clock after that clearing tick.
- R3: `top_mode` picks TOP: 0 gives 0x00FF, 1 gives 0x01FF, 2 gives 0x03FF, 3 gives the period register, 4 gives the active compare value of channel A, and 5 to 7 behave as 0.
- R4: A period register write takes effect on the next tick. If the new value is below the current count, the counter runs on to 0xFFFF and wraps to 0 without raising `ovf_flag`, then clears at the new TOP on a later pass.
- R5: `wr_addr` 0 writes the channel A buffer, 1 the channel B buffer and 2 the period register. A buffered compare value becomes active only on the tick at which the counter equals TOP.
- R6: While `top_mode` selects a fixed TOP, the bits of a compare write above that TOP width are stored as zero.
- R7: `match_a` and `match_b` are high for exactly one clock after a tick on which the counter equals that channel's active compare value.
- R8: In output mode 2 (`com_x` = 2) the pin goes high on the tick that clears the counter and goes low on a match tick. When both happen on the same tick, the pin goes high. The pin is therefore high while count <= compare: a one-tick spike for compare 0, and always high for compare equal to TOP.
- R9: Output mode 3 gives the exact complement of the mode 2 waveform.
- R10: In output mode 1, pin A toggles on every channel A match, so compare 0 with TOP 0 gives a square wave at the clock frequency divided by 2. Pin B in mode 1 and either pin in mode 0 stay low.
- R11: While `top_mode` is 4, pin A stays low in modes 2 and 3 but still toggles in mode 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the prescaler and counter |
| presc_sel | input | 3 | Tick divider select (0..4 = 1, 8, 64, 256, 1024) |
| top_mode | input | 3 | Period limit source |
| com_a | input | 2 | Output mode of channel A |
| com_b | input | 2 | Output mode of channel B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 cmp A, 1 cmp B, 2 period) |
| wr_data | input | 16 | Register write data |
| count | output | 16 | Current counter value |
| ovf_flag | output | 1 | One-clock pulse after clearing at TOP |
| match_a | output | 1 | One-clock pulse after a channel A match |
| match_b | output | 1 | One-clock pulse after a channel B match |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |

## Verification
The hard coincidence is a compare match that falls on the same tick as the clear at TOP. This happens when a compare equals TOP, and also when the compare buffer reloads on that tick. The bench provokes it by setting channel B's compare to TOP, and to zero, in a short period. It then checks on every cycle that the pin level equals count <= compare, or its complement in inverted mode. A second check writes a new compare just after a match. It expects the next match to appear only after an overflow pulse, and at the new value.

// File: rtl/fpwm_pkg.sv
// Shared constants and types for the fast PWM timer.
// Assumes a counter of at least 10 bits so the fixed TOP widths fit.
package fpwm_pkg;
    localparam int FIXED8_TOP  = 16'h00FF;
    localparam int FIXED9_TOP  = 16'h01FF;
    localparam int FIXED10_TOP = 16'h03FF;

    typedef enum logic [1:0] {
        OUT_OFF    = 2'd0,
        OUT_TOGGLE = 2'd1,
        OUT_PWM    = 2'd2,
        OUT_PWM_N  = 2'd3
    } out_mode_e;

    typedef enum logic [1:0] {
        REG_CMP_A  = 2'd0,
        REG_CMP_B  = 2'd1,
        REG_PERIOD = 2'd2
    } reg_sel_e;

    typedef enum logic [2:0] {
        TOP_FIX8   = 3'd0,
        TOP_FIX9   = 3'd1,
        TOP_FIX10  = 3'd2,
        TOP_PERIOD = 3'd3,
        TOP_CMP_A  = 3'd4
    } top_src_e;
endpackage

// File: rtl/fpwm_prescaler.sv
// Tick generator: emits a one-clock tick every N enabled clocks.
// Assumes DIV_W >= 10 so the largest divider (1024) fits.
module fpwm_prescaler #(
    parameter int DIV_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_mask;
    logic             sel_ok;

    // Decode the divider select into a low-bit mask (N-1).
    always_comb begin
        sel_ok = 1'b1;
        case (sel)
            3'd0:    div_mask = '0;
            3'd1:    div_mask = DIV_W'(7);
            3'd2:    div_mask = DIV_W'(63);
            3'd3:    div_mask = DIV_W'(255);
            3'd4:    div_mask = DIV_W'(1023);
            default: begin div_mask = '1; sel_ok = 1'b0; end
        endcase
    end

    // Free-running divider, cleared while the timer is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) div_cnt <= '0;
        else                   div_cnt <= div_cnt + 1'b1;
    end

    assign tick = enable && sel_ok && ((div_cnt & div_mask) == div_mask);
endmodule

// File: rtl/fpwm_counter.sv
// Up-counter that clears after TOP and pulses an overflow flag.
// Assumes top_val is stable around the tick; wraps through all-ones if above TOP.
module fpwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] top_val,
    output logic [CNT_W-1:0] count,
    output logic             at_top,
    output logic             ovf_flag
);
    assign at_top = (count == top_val);

    // Advance on ticks; clear at TOP and flag it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            ovf_flag <= 1'b0;
        end else begin
            ovf_flag <= tick && at_top;
            if (tick) count <= at_top ? '0 : count + 1'b1;
        end
    end
endmodule

// File: rtl/fpwm_channel.sv
// One compare channel: write buffer, active compare, match flag, waveform.
// Assumes the buffer is written at most once per clock; reload happens at TOP.
module fpwm_channel
    import fpwm_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter bit HAS_TOGGLE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             at_top,
    input  logic [CNT_W-1:0] count,
    input  logic             wr_stb,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] wr_mask,
    input  out_mode_e        mode,
    input  logic             pwm_allowed,
    output logic [CNT_W-1:0] active_cmp,
    output logic             match_flag,
    output logic             wave
);
    logic [CNT_W-1:0] buf_cmp;
    logic             hit;
    logic             pwm_q;
    logic             tog_q;

    assign hit = tick && (count == active_cmp);

    // Capture software writes, trimmed to the TOP width.
    always_ff @(posedge clk) begin
        if (!rst_n)      buf_cmp <= '0;
        else if (wr_stb) buf_cmp <= wr_data & wr_mask;
    end

    // Copy the buffer into the active compare at TOP.
    always_ff @(posedge clk) begin
        if (!rst_n)              active_cmp <= '0;
        else if (tick && at_top) active_cmp <= buf_cmp;
    end

    // Match pulse, PWM level (set at TOP wins over clear) and toggle state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_flag <= 1'b0;
            pwm_q      <= 1'b0;
            tog_q      <= 1'b0;
        end else begin
            match_flag <= hit;
            if (tick && at_top) pwm_q <= 1'b1;
            else if (hit)       pwm_q <= 1'b0;
            if (hit)            tog_q <= ~tog_q;
        end
    end

    // Shape the pin according to the output mode.
    always_comb begin
        case (mode)
            OUT_TOGGLE: wave = HAS_TOGGLE ? tog_q : 1'b0;
            OUT_PWM:    wave = pwm_allowed && pwm_q;
            OUT_PWM_N:  wave = pwm_allowed && !pwm_q;
            default:    wave = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpwm_timer.sv
// Fast PWM timer top: prescaler, counter, TOP source select, two channels.
// Assumes CNT_W >= 10; channel A (index 0) has the toggle mode and can act as TOP.
module fpwm_timer
    import fpwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 10,
    parameter int N_CHAN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [2:0]       presc_sel,
    input  logic [2:0]       top_mode,
    input  logic [1:0]       com_a,
    input  logic [1:0]       com_b,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag,
    output logic             match_a,
    output logic             match_b,
    output logic             wave_a,
    output logic             wave_b
);
    logic             tick;
    logic             at_top;
    logic [CNT_W-1:0] top_val;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] wr_mask;
    logic [CNT_W-1:0] act_a_w;
    logic             cmp_a_is_top;
    logic [CNT_W-1:0] act_cmp [N_CHAN];
    logic [N_CHAN-1:0] match_v;
    logic [N_CHAN-1:0] wave_v;
    out_mode_e         mode_v [N_CHAN];

    assign act_a_w      = act_cmp[0];
    assign cmp_a_is_top = (top_mode == TOP_CMP_A);
    assign mode_v[0]    = out_mode_e'(com_a);
    assign mode_v[1]    = out_mode_e'(com_b);

    // Select TOP and the write mask that matches its width.
    always_comb begin
        case (top_mode)
            TOP_FIX9:   top_val = CNT_W'(FIXED9_TOP);
            TOP_FIX10:  top_val = CNT_W'(FIXED10_TOP);
            TOP_PERIOD: top_val = period_q;
            TOP_CMP_A:  top_val = act_a_w;
            default:    top_val = CNT_W'(FIXED8_TOP);
        endcase
        wr_mask = (top_mode == TOP_PERIOD || cmp_a_is_top) ? '1 : top_val;
    end

    // Unbuffered period register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  period_q <= '0;
        else if (wr_en && wr_addr == 2'(REG_PERIOD)) period_q <= wr_data;
    end

    fpwm_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sel(presc_sel), .tick(tick)
    );

    fpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .top_val(top_val),
        .count(count), .at_top(at_top), .ovf_flag(ovf_flag)
    );

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        fpwm_channel #(.CNT_W(CNT_W), .HAS_TOGGLE(g == 0)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick), .at_top(at_top), .count(count),
            .wr_stb(wr_en && wr_addr == 2'(g)), .wr_data(wr_data), .wr_mask(wr_mask),
            .mode(mode_v[g]), .pwm_allowed(!(g == 0 && cmp_a_is_top)),
            .active_cmp(act_cmp[g]), .match_flag(match_v[g]), .wave(wave_v[g])
        );
    end

    assign match_a = match_v[0];
    assign match_b = match_v[1];
    assign wave_a  = wave_v[0];
    assign wave_b  = wave_v[1];
endmodule

// File: rtl/fpwm_timer_chk.sv
// Property checker for fpwm_timer, bound to every instance.
// Assumes it observes the tick, TOP and channel A active compare from inside.
module fpwm_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [CNT_W-1:0] top_val,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] act_a,
    input logic             ovf_flag,
    input logic             match_a,
    input logic [2:0]       top_mode,
    input logic [1:0]       com_a,
    input logic             wave_a
);
    assert_clear_at_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == top_val) |=> (count == '0 && ovf_flag));

    assert_ovf_means_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> (count == '0));

    assert_hold_without_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

    assert_wrap_no_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == '1 && top_val != '1) |=> (count == '0 && !ovf_flag));

    assert_reload_only_at_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && count == top_val) |=> $stable(act_a));

    assert_match_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        match_a |-> $past(tick));

    assert_cmp_top_pin_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (top_mode == 3'd4 && com_a != 2'd1) |-> !wave_a);
endmodule

bind fpwm_timer fpwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .top_val(top_val), .count(count),
    .act_a(act_a_w), .ovf_flag(ovf_flag), .match_a(match_a),
    .top_mode(top_mode), .com_a(com_a), .wave_a(wave_a)
);

// File: tb/fpwm_timer_test.sv
// Directed bench for fpwm_timer: one task per scenario, 50 MHz clock.
module fpwm_timer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic [2:0]  presc_sel, top_mode;
    logic [1:0]  com_a, com_b, wr_addr;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] count;
    logic        ovf_flag, match_a, match_b, wave_a, wave_b;
    int          checks = 0;
    int          failures = 0;
    int          cycles = 0;

    fpwm_timer uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .presc_sel(presc_sel),
        .top_mode(top_mode), .com_a(com_a), .com_b(com_b), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .count(count), .ovf_flag(ovf_flag),
        .match_a(match_a), .match_b(match_b), .wave_a(wave_a), .wave_b(wave_b)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] tm);
        @(negedge clk);
        rst_n = 1'b0; enable = 1'b0; presc_sel = 3'd0; top_mode = tm;
        com_a = 2'd0; com_b = 2'd0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ovf(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int k = 0; k < 70000 && !ovf_flag; k++) @(negedge clk);
        end
    endtask

    task automatic wait_match_b(input int top, output int val, output bit saw_ovf);
        saw_ovf = 1'b0; val = -1;
        for (int k = 0; k < 70000; k++) begin
            @(negedge clk);
            if (ovf_flag) saw_ovf = 1'b1;
            if (match_b) begin
                val = (count == 0) ? top : int'(count) - 1;
                break;
            end
        end
    endtask

    task automatic t_reset_state;
        do_reset(3'd0);
        @(negedge clk);
        check(count == 0 && !ovf_flag && !match_a && !match_b, "R2 reset count/flags",
              int'(count), 0);
        check(!wave_a && !wave_b, "R10 reset pins low", int'({wave_a, wave_b}), 0);
    endtask

    task automatic t_prescale(input logic [2:0] sel, input int n);
        int gap;
        logic [15:0] prev;
        do_reset(3'd0);
        presc_sel = sel; enable = 1'b1;
        prev = count;
        for (int k = 0; k < 3000 && count == prev; k++) @(negedge clk);
        prev = count; gap = 0;
        for (int k = 0; k < 3000 && count == prev; k++) begin
            @(negedge clk); gap++;
        end
        check(gap == n, "R1 tick spacing", gap, n);
    endtask

    task automatic t_hold;
        logic [15:0] held;
        do_reset(3'd0);
        enable = 1'b1;
        repeat (5) @(negedge clk);
        enable = 1'b0; held = count;
        repeat (20) @(negedge clk);
        check(count == held, "R1 hold when disabled", int'(count), int'(held));
        enable = 1'b1; presc_sel = 3'd6;
        repeat (20) @(negedge clk);
        check(count == held, "R1 hold on bad select", int'(count), int'(held));
    endtask

    task automatic t_fixed_top(input logic [2:0] tm, input int exp_top);
        int mx = 0;
        do_reset(tm);
        enable = 1'b1;
        for (int k = 0; k < 1100; k++) begin
            @(negedge clk);
            if (int'(count) > mx) mx = int'(count);
        end
        check(mx == exp_top, "R3 fixed TOP", mx, exp_top);
    endtask

    task automatic t_clear_and_ovf;
        do_reset(3'd0);
        enable = 1'b1;
        for (int k = 0; k < 400 && count != 16'h00FF; k++) @(negedge clk);
        @(negedge clk);
        check(count == 0 && ovf_flag, "R2 clear with overflow", int'(count), 0);
        @(negedge clk);
        check(count == 1 && !ovf_flag, "R2 overflow one clock", int'(ovf_flag), 0);
    endtask

    task automatic t_period_overshoot;
        bit early_ovf = 1'b0;
        do_reset(3'd3);
        write_reg(2'd2, 16'd1000);
        enable = 1'b1;
        for (int k = 0; k < 2000 && count != 16'd500; k++) @(negedge clk);
        write_reg(2'd2, 16'd100);
        for (int k = 0; k < 70000 && count != 16'hFFFF; k++) begin
            if (ovf_flag) early_ovf = 1'b1;
            @(negedge clk);
        end
        check(!early_ovf && count == 16'hFFFF, "R4 runs to all-ones", int'(count), 65535);
        @(negedge clk);
        check(count == 0 && !ovf_flag, "R4 wrap without overflow", int'(ovf_flag), 0);
        for (int k = 0; k < 200 && count != 16'd100; k++) @(negedge clk);
        @(negedge clk);
        check(count == 0 && ovf_flag, "R4 clears at new TOP", int'(count), 0);
    endtask

    task automatic t_buffered;
        int v; bit so;
        do_reset(3'd3);
        write_reg(2'd2, 16'd20);
        write_reg(2'd1, 16'd5);
        enable = 1'b1;
        wait_ovf(2);
        wait_match_b(20, v, so);
        check(v == 5, "R7 match at active compare", v, 5);
        @(negedge clk);
        check(!match_b, "R7 match one clock", int'(match_b), 0);
        write_reg(2'd1, 16'd15);
        wait_match_b(20, v, so);
        check(v == 15 && so, "R5 new compare after TOP", v, 15);
    endtask

    task automatic t_mask;
        int v; bit so;
        do_reset(3'd0);
        write_reg(2'd1, 16'h0123);
        enable = 1'b1;
        wait_ovf(1);
        wait_match_b(255, v, so);
        check(v == 16'h23, "R6 masked compare", v, 16'h23);
    endtask

    task automatic t_levels(input logic [1:0] mode, input int cmp, input string tag);
        int bad = 0;
        com_b = mode;
        write_reg(2'd1, 16'(cmp));
        wait_ovf(2);
        for (int k = 0; k < 25; k++) begin
            @(negedge clk);
            if (wave_b != ((int'(count) <= cmp) ^ (mode == 2'd3))) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic t_pwm_shapes;
        do_reset(3'd3);
        write_reg(2'd2, 16'd9);
        enable = 1'b1;
        t_levels(2'd2, 4, "R8 mode 2 mid duty");
        t_levels(2'd2, 0, "R8 mode 2 spike at zero");
        t_levels(2'd2, 9, "R8 mode 2 compare at TOP");
        t_levels(2'd3, 4, "R9 mode 3 inverse");
        t_levels(2'd3, 9, "R9 mode 3 compare at TOP");
    endtask

    task automatic t_toggle;
        int bad = 0, edges = 0;
        logic prev;
        do_reset(3'd4);
        com_a = 2'd1; com_b = 2'd1;
        write_reg(2'd1, 16'd0);
        enable = 1'b1;
        repeat (3) @(negedge clk);
        prev = wave_a;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (wave_a == prev) bad++;
            prev = wave_a;
        end
        check(bad == 0, "R10 toggle every clock", bad, 0);
        check(!wave_b, "R10 pin B mode 1 low", int'(wave_b), 0);
        write_reg(2'd0, 16'd3);
        wait_ovf(2);
        prev = wave_a;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (wave_a != prev) edges++;
            prev = wave_a;
        end
        check(edges == 4, "R11 toggle with compare as TOP", edges, 4);
        com_a = 2'd2; bad = 0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (wave_a) bad++;
        end
        check(bad == 0, "R11 mode 2 quiet on A", bad, 0);
        com_b = 2'd0; bad = 0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (wave_b) bad++;
        end
        check(bad == 0, "R10 mode 0 low", bad, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        t_reset_state();
        t_prescale(3'd0, 1);
        t_prescale(3'd1, 8);
        t_prescale(3'd2, 64);
        t_prescale(3'd4, 1024);
        t_hold();
        t_fixed_top(3'd0, 16'h00FF);
        t_fixed_top(3'd1, 16'h01FF);
        t_fixed_top(3'd2, 16'h03FF);
        t_clear_and_ovf();
        t_period_overshoot();
        t_buffered();
        t_mask();
        t_pwm_shapes();
        t_toggle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule